// File: doc/BRIEF.md
# Cascadable Multiply-Accumulate Slice

This block is one arithmetic slice meant to be tiled in columns. Two signed operands are multiplied as two partial products, which then meet a third term in a wide adder that sign-extends every input. The third term is picked per operation: a constant zero, the slice's own registered result (running accumulation), an external addend port, or the cascade input coming from the slice below. The cascade input can first be shifted arithmetically right by a fixed amount, so that a column of slices fed with unsigned operand chunks builds one product wider than a single multiplier. An alternate mode skips the multiplier and adds the two operands directly to the third term.

The operands and the per-operation controls enter a configurable input register chain. Then come an optional register after the multiplier and a mandatory result register. Each of the three groups has its own clock enable. A single synchronous reset clears every register. The registered result drives both the result port and the cascade output, so the next slice up can pick it as its cascade term.

Top module: `mac_slice`

## Requirements
- R1: With third-term select `00` (zero), product mode (`mode_add`=0) and no subtract, the result equals the signed product of `op_a` and `op_b`, both taken as 18-bit two's complement.
- R2: With select `10` (external), the result equals `addend` plus the product.
- R3: With `do_sub`=1, the result equals the selected third term minus the product term (or minus the operand sum in add mode).
- R4: With select `01` (accumulator), each cycle in which `ce_out` is high replaces the result with the previous result plus the product term, or minus it when `do_sub`=1. Accumulation starts from zero after reset.
- R5: With select `11` (cascade) and `cas_shr`=0, the result equals `cas_in` plus the product.
- R6: With select `11` and `cas_shr`=1, `cas_in` is shifted right arithmetically by 17 bit positions, sign bit copied in, before it is added.
- R7: With `mode_add`=1, the product term is replaced by the sign-extended sum of `op_a` and `op_b`.
- R8: The 48-bit result wraps modulo 2^48 and never saturates.
- R9: `cas_out` carries the same value as `result` in every cycle.
- R10: A cycle with `rst` high clears every pipeline register. From the next cycle on, `result` and `cas_out` read zero.
- R11: While a stage's clock enable is low and `rst` is low, that stage's registers hold. In particular, `result` stays unchanged while `ce_out` is low, whatever the inputs do.
- R12: With all enables high, an operand and control change reaches `result` after IN_STAGES + MUL_STAGE + 1 rising edges (3 with the defaults), and not earlier. `addend` and `cas_in` feed the adder without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset for all stages |
| ce_in | input | 1 | Clock enable of the operand/control input chain |
| ce_mul | input | 1 | Clock enable of the post-multiply register |
| ce_out | input | 1 | Clock enable of the result register |
| op_a | input | 18 | Signed multiplicand |
| op_b | input | 18 | Signed multiplier |
| addend | input | 48 | External third term |
| cas_in | input | 48 | Cascade third term from the neighbouring slice |
| sel_z | input | 2 | Third-term select: 00 zero, 01 accumulator, 10 external, 11 cascade |
| do_sub | input | 1 | 1: third term minus product term |
| cas_shr | input | 1 | 1: shift the cascade term right by 17 before use |
| mode_add | input | 1 | 1: use op_a + op_b in place of the product |
| result | output | 48 | Registered result |
| cas_out | output | 48 | Registered result toward the next slice |

## Verification
The bench aims at the operand extremes: the most negative value squared, the most negative times the most positive, and the largest positive square. A multiplier that splits the multiplier operand wrongly, or sign-extends its low partial product, gives wrong high bits there. A negative cascade term is pushed through the 17-bit shift, so a logical shift in place of an arithmetic one shows as a large positive result. A sum that crosses 2^47 checks wrap against saturation. Directed runs count accumulation steps against `ce_out`, check the hold while the inputs move, and pin the output latency to the exact edge.

// File: rtl/mac_pkg.sv
package mac_pkg;

   // Third-term select of the post-multiply adder
   typedef enum logic [1:0] {
      Z_ZERO = 2'b00,
      Z_ACC  = 2'b01,
      Z_EXT  = 2'b10,
      Z_CAS  = 2'b11
   } zsel_e;

   // Per-operation controls, travelling with the operands
   typedef struct packed {
      zsel_e zsel;
      logic  sub;
      logic  shr;
      logic  addm;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/mac_pipe.sv
module mac_pipe #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (DEPTH < 0 || DEPTH > 2) begin : g_bad_depth
      $error("mac_pipe: DEPTH must be 0, 1 or 2");
   end

   if (DEPTH == 0) begin : g_wire
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] stg [DEPTH];

      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst)     stg[i] <= '0;
               else if (ce) stg[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst)     stg[i] <= '0;
               else if (ce) stg[i] <= stg[i-1];
            end
         end
      end

      assign q = stg[DEPTH-1];

      AST_PIPE_CLEAR: assert property (@(posedge clk)
         rst |=> (q == '0)); // R10
      AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (rst)
         !ce |=> $stable(q)); // R11
   end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int A_W  = 18,
   parameter int B_W  = 18,
   parameter int PP_W = 36
) (
   input  logic [A_W-1:0]  a,
   input  logic [B_W-1:0]  b,
   input  logic            addm,
   output logic [PP_W-1:0] x,
   output logic [PP_W-1:0] y
);

   localparam int LO_W = B_W / 2;
   localparam int HI_W = B_W - LO_W;

   if (PP_W < A_W + B_W) begin : g_bad_width
      $error("mac_mult: PP_W must hold the full product");
   end

   logic signed [PP_W-1:0] a_x;
   logic signed [PP_W-1:0] b_x;
   logic signed [PP_W-1:0] blo_x;
   logic signed [PP_W-1:0] bhi_x;
   logic signed [PP_W-1:0] pp_lo;
   logic signed [PP_W-1:0] pp_hi;

   always_comb begin
      a_x   = {{(PP_W-A_W){a[A_W-1]}}, a};
      b_x   = {{(PP_W-B_W){b[B_W-1]}}, b};
      // low chunk of b is unsigned, high chunk carries the sign
      blo_x = {{(PP_W-LO_W){1'b0}}, b[LO_W-1:0]};
      bhi_x = {{(PP_W-HI_W){b[B_W-1]}}, b[B_W-1:LO_W]};
      pp_lo = a_x * blo_x;
      pp_hi = (a_x * bhi_x) <<< LO_W;
   end

   // add mode: the two operands replace the partial products
   assign x = addm ? a_x : pp_lo;
   assign y = addm ? b_x : pp_hi;

endmodule

// File: rtl/mac_sum.sv
module mac_sum
   import mac_pkg::*;
#(
   parameter int PP_W  = 36,
   parameter int P_W   = 48,
   parameter int SHIFT = 17
) (
   input  logic [PP_W-1:0] x,
   input  logic [PP_W-1:0] y,
   input  ctl_t            ctl,
   input  logic [P_W-1:0]  acc,
   input  logic [P_W-1:0]  ext,
   input  logic [P_W-1:0]  cas,
   output logic [P_W-1:0]  sum
);

   if (SHIFT >= P_W) begin : g_bad_shift
      $error("mac_sum: SHIFT must be below P_W");
   end

   logic signed [P_W-1:0] xs;
   logic signed [P_W-1:0] ys;
   logic signed [P_W-1:0] z;
   logic signed [P_W-1:0] cas_adj;
   logic signed [P_W-1:0] xy;

   always_comb begin
      xs      = {{(P_W-PP_W){x[PP_W-1]}}, x};
      ys      = {{(P_W-PP_W){y[PP_W-1]}}, y};
      cas_adj = ctl.shr ? ($signed(cas) >>> SHIFT) : $signed(cas);
      unique case (ctl.zsel)
         Z_ZERO:  z = '0;
         Z_ACC:   z = $signed(acc);
         Z_EXT:   z = $signed(ext);
         default: z = cas_adj;
      endcase
      xy  = xs + ys;
      sum = ctl.sub ? (z - xy) : (z + xy);
   end

endmodule

// File: rtl/mac_slice.sv
module mac_slice
   import mac_pkg::*;
#(
   parameter int A_W       = 18,
   parameter int B_W       = 18,
   parameter int P_W       = 48,
   parameter int CAS_SHIFT = 17,
   parameter int IN_STAGES = 1,
   parameter int MUL_STAGE = 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           ce_in,
   input  logic           ce_mul,
   input  logic           ce_out,
   input  logic [A_W-1:0] op_a,
   input  logic [B_W-1:0] op_b,
   input  logic [P_W-1:0] addend,
   input  logic [P_W-1:0] cas_in,
   input  logic [1:0]     sel_z,
   input  logic           do_sub,
   input  logic           cas_shr,
   input  logic           mode_add,
   output logic [P_W-1:0] result,
   output logic [P_W-1:0] cas_out
);

   localparam int PP_W  = A_W + B_W;
   localparam int IN_W  = A_W + B_W + CTL_W;
   localparam int MUL_W = 2 * PP_W + CTL_W;

   if (P_W < PP_W + 2) begin : g_bad_pw
      $error("mac_slice: P_W too narrow for the product");
   end
   if (MUL_STAGE < 0 || MUL_STAGE > 1) begin : g_bad_mul
      $error("mac_slice: MUL_STAGE must be 0 or 1");
   end

   // ---------------- input stage ----------------
   ctl_t            ctl_d;
   logic [IN_W-1:0] in_d;
   logic [IN_W-1:0] in_q;
   logic [A_W-1:0]  a_q;
   logic [B_W-1:0]  b_q;
   ctl_t            ctl_q;

   always_comb begin
      ctl_d.zsel = zsel_e'(sel_z);
      ctl_d.sub  = do_sub;
      ctl_d.shr  = cas_shr;
      ctl_d.addm = mode_add;
   end

   assign in_d = {op_a, op_b, ctl_d};

   mac_pipe #(.W(IN_W), .DEPTH(IN_STAGES)) i_in_pipe (
      .clk (clk),
      .rst (rst),
      .ce  (ce_in),
      .d   (in_d),
      .q   (in_q)
   );

   assign {a_q, b_q, ctl_q} = in_q;

   // ---------------- multiplier ----------------
   logic [PP_W-1:0] x_d;
   logic [PP_W-1:0] y_d;

   mac_mult #(.A_W(A_W), .B_W(B_W), .PP_W(PP_W)) i_mult (
      .a    (a_q),
      .b    (b_q),
      .addm (ctl_q.addm),
      .x    (x_d),
      .y    (y_d)
   );

   // ---------------- post-multiply stage ----------------
   logic [MUL_W-1:0] mul_q;
   logic [PP_W-1:0]  x_q;
   logic [PP_W-1:0]  y_q;
   ctl_t             mctl_q;

   mac_pipe #(.W(MUL_W), .DEPTH(MUL_STAGE)) i_mul_pipe (
      .clk (clk),
      .rst (rst),
      .ce  (ce_mul),
      .d   ({x_d, y_d, ctl_q}),
      .q   (mul_q)
   );

   assign {x_q, y_q, mctl_q} = mul_q;

   // ---------------- adder and result register ----------------
   logic [P_W-1:0] sum;
   logic [P_W-1:0] p_q;

   mac_sum #(.PP_W(PP_W), .P_W(P_W), .SHIFT(CAS_SHIFT)) i_sum (
      .x   (x_q),
      .y   (y_q),
      .ctl (mctl_q),
      .acc (p_q),
      .ext (addend),
      .cas (cas_in),
      .sum (sum)
   );

   always_ff @(posedge clk) begin
      if (rst)         p_q <= '0;
      else if (ce_out) p_q <= sum;
   end

   assign result  = p_q;
   assign cas_out = p_q;

   // ---------------- assertions ----------------
   AST_OUT_CLEAR: assert property (@(posedge clk)
      rst |=> (result == '0 && cas_out == '0)); // R10
   AST_OUT_FREEZE: assert property (@(posedge clk) disable iff (rst)
      !ce_out |=> $stable(result)); // R11
   AST_ZERO_TERM: assert property (@(posedge clk) disable iff (rst)
      (ce_out && mctl_q.zsel == Z_ZERO && x_q == '0 && y_q == '0)
      |=> (result == '0)); // R1
   AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
      (ce_out && mctl_q.zsel == Z_ACC && x_q == '0 && y_q == '0)
      |=> $stable(result)); // R4

endmodule

// File: tb/test_mac_slice.sv
module test_mac_slice;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;   // IN_STAGES + MUL_STAGE + 1

   typedef struct packed {
      logic [17:0] a;
      logic [17:0] b;
      logic [47:0] c;
      logic [47:0] cin;
      logic [1:0]  zs;
      logic        sub;
      logic        shr;
      logic        addm;
      logic [47:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VEC [NVEC] = '{
      '{18'd3,       18'd5,       48'd0,              48'd0,              2'b00, 1'b0, 1'b0, 1'b0, 48'd15,             8'd1}, // R1
      '{18'h3FFFC,   18'd7,       48'd100,            48'd0,              2'b10, 1'b0, 1'b0, 1'b0, 48'd72,             8'd2}, // R2
      '{18'h3FFFC,   18'd7,       48'd100,            48'd0,              2'b10, 1'b1, 1'b0, 1'b0, 48'd128,            8'd3}, // R3
      '{18'd2,       18'd2,       48'd0,              48'd1000,           2'b11, 1'b0, 1'b0, 1'b0, 48'd1004,           8'd5}, // R5
      '{18'd1,       18'd1,       48'd0,              48'h0000_0006_0000, 2'b11, 1'b0, 1'b1, 1'b0, 48'd4,              8'd6}, // R6
      '{18'd0,       18'd5,       48'd0,              48'hFFFF_FFFE_0000, 2'b11, 1'b0, 1'b1, 1'b0, 48'hFFFF_FFFF_FFFF, 8'd6}, // R6
      '{18'h3FFF6,   18'd20,      48'd5,              48'd0,              2'b10, 1'b0, 1'b0, 1'b1, 48'd15,             8'd7}, // R7
      '{18'h3FFF6,   18'd20,      48'd5,              48'd0,              2'b10, 1'b1, 1'b0, 1'b1, 48'hFFFF_FFFF_FFFB, 8'd7}, // R7
      '{18'h20000,   18'h20000,   48'h7FFF_FFFF_FFFF, 48'd0,              2'b10, 1'b0, 1'b0, 1'b0, 48'h8003_FFFF_FFFF, 8'd8}, // R8
      '{18'h1FFFF,   18'h1FFFF,   48'd0,              48'd0,              2'b00, 1'b0, 1'b0, 1'b0, 48'h0003_FFFC_0001, 8'd1}, // R1
      '{18'h20000,   18'h1FFFF,   48'd0,              48'd0,              2'b00, 1'b0, 1'b0, 1'b0, 48'hFFFC_0002_0000, 8'd1}, // R1
      '{18'h3FFFF,   18'h3FFFF,   48'd0,              48'd0,              2'b11, 1'b1, 1'b0, 1'b0, 48'hFFFF_FFFF_FFFF, 8'd3}  // R3
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ce_in = 1'b1, ce_mul = 1'b1, ce_out = 1'b1;
   logic [17:0] op_a = '0, op_b = '0;
   logic [47:0] addend = '0, cas_in = '0;
   logic [1:0]  sel_z = 2'b00;
   logic        do_sub = 1'b0, cas_shr = 1'b0, mode_add = 1'b0;
   logic [47:0] result, cas_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_slice i_mac_slice (
      .clk      (clk),
      .rst      (rst),
      .ce_in    (ce_in),
      .ce_mul   (ce_mul),
      .ce_out   (ce_out),
      .op_a     (op_a),
      .op_b     (op_b),
      .addend   (addend),
      .cas_in   (cas_in),
      .sel_z    (sel_z),
      .do_sub   (do_sub),
      .cas_shr  (cas_shr),
      .mode_add (mode_add),
      .result   (result),
      .cas_out  (cas_out)
   );

   task automatic check(input logic [47:0] act, input logic [47:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // reset state (R10)
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(result, 48'd0, "R10 result after reset");
      check(cas_out, 48'd0, "R10 cas_out after reset");

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         op_a     = VEC[i].a;
         op_b     = VEC[i].b;
         addend   = VEC[i].c;
         cas_in   = VEC[i].cin;
         sel_z    = VEC[i].zs;
         do_sub   = VEC[i].sub;
         cas_shr  = VEC[i].shr;
         mode_add = VEC[i].addm;
         repeat (LAT + 1) @(negedge clk);
         check(result, VEC[i].exp, $sformatf("vector %0d R%0d", i, VEC[i].req));
         check(cas_out, result, $sformatf("vector %0d R9 cascade mirror", i));
      end

      // latency: previous result is all ones; new value after exactly LAT edges (R12)
      op_a = 18'd2; op_b = 18'd2; sel_z = 2'b00; do_sub = 1'b0;
      cas_in = '0;
      repeat (LAT - 1) @(negedge clk);
      check(result, 48'hFFFF_FFFF_FFFF, "R12 not yet updated");
      @(negedge clk);
      check(result, 48'd4, "R12 updated at latency");

      // accumulation (R4)
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(result, 48'd0, "R10 mid-run reset");
      ce_out = 1'b0;
      op_a = 18'd7; op_b = 18'h3FFFD; sel_z = 2'b01; do_sub = 1'b0;
      repeat (LAT) @(negedge clk);
      check(result, 48'd0, "R11 hold during fill");
      ce_out = 1'b1;
      repeat (5) @(negedge clk);
      ce_out = 1'b0;
      check(result, 48'hFFFF_FFFF_FF97, "R4 five accumulate steps");
      do_sub = 1'b1;
      repeat (LAT) @(negedge clk);
      check(result, 48'hFFFF_FFFF_FF97, "R11 hold with new controls");
      ce_out = 1'b1;
      repeat (3) @(negedge clk);
      ce_out = 1'b0;
      check(result, 48'hFFFF_FFFF_FFD6, "R4 R3 three subtract steps");

      // hold while inputs move (R11)
      op_a = 18'h1FFFF; op_b = 18'h12345; sel_z = 2'b10; addend = 48'h1234_5678_9ABC;
      repeat (LAT + 2) @(negedge clk);
      check(result, 48'hFFFF_FFFF_FFD6, "R11 result frozen");
      check(cas_out, 48'hFFFF_FFFF_FFD6, "R9 R11 cascade frozen");

      finish_run();
   end

endmodule